// File: doc/BRIEF.md
# Saturating threshold event counter

A counter field, 32 bits wide by default, that hardware steps up and down while software can read it at any time and overwrite it. Each cycle an active-high up request adds an up step and an active-high down request subtracts a down step. Each step is either a fixed parameter or, when the dynamic-step variant is selected at build time, a value taken from a step input of its own width. When both requests arrive together, only the net change is applied.

Each direction has its own limit and its own mode input. In saturate mode a rising count stops at a ceiling and a falling count stops at a floor. In wrap mode the value rolls over modulo 2^WIDTH, and the register update carries a one-cycle overflow or underflow pulse. Two level flags report when the value sits at or above an upper threshold, or at or below a lower threshold. Software access is a write strobe with data, plus a read-data output that always shows the held value.

Top module: `evt_counter`

## Requirements
- R1: After reset the value is 0 and both wrap pulses are low.
- R2: A software write loads `sw_wdata_i` on the next edge and overrides any up or down request in the same cycle. The wrap pulses stay low for that update.
- R3: With DYN_STEP=0 an up request adds INC_STEP (default 2) and a down request subtracts DEC_STEP (default 2). The step inputs have no effect.
- R4: With DYN_STEP=1 the step for each direction is the matching STEP_W-bit step input, zero-extended.
- R5: When up and down requests are both high, the signed difference of the two steps is applied in one update. Only that net direction's mode and limit apply. A zero net change holds the value.
- R6: With `inc_sat_i`=1, a net increase whose result would exceed INC_CEIL (default 15) gives INC_CEIL. If the value was already above INC_CEIL, it is left unchanged.
- R7: With `dec_sat_i`=1, a net decrease whose result would fall below DEC_FLOOR (default 5) gives DEC_FLOOR. If the value was already below DEC_FLOOR, it is left unchanged.
- R8: With `inc_sat_i`=0, a net increase past 2^WIDTH-1 wraps modulo 2^WIDTH. `ovf_o` is high for exactly the cycle that shows the wrapped value.
- R9: With `dec_sat_i`=0, a net decrease below 0 wraps modulo 2^WIDTH. `unf_o` is high for exactly the cycle that shows the wrapped value.
- R10: `inc_thr_o` is high whenever the held value is at or above INC_THR (default 10). `dec_thr_o` is high whenever it is at or below DEC_THR (default 10).
- R11: With no write and no request, the value holds and neither pulse fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_i | input | 1 | Up request |
| dec_i | input | 1 | Down request |
| inc_step_i | input | STEP_W | Up step (dynamic variant only) |
| dec_step_i | input | STEP_W | Down step (dynamic variant only) |
| inc_sat_i | input | 1 | 1 = saturate at ceiling, 0 = wrap upward |
| dec_sat_i | input | 1 | 1 = saturate at floor, 0 = wrap downward |
| sw_we_i | input | 1 | Software write strobe |
| sw_wdata_i | input | WIDTH | Software write data |
| sw_rdata_o | output | WIDTH | Held counter value |
| inc_thr_o | output | 1 | At or above upper threshold |
| dec_thr_o | output | 1 | At or below lower threshold |
| ovf_o | output | 1 | Upward wrap pulse |
| unf_o | output | 1 | Downward wrap pulse |

## Verification
Random request pairs, mode bits and step inputs are applied to a fixed-step instance and a dynamic-step instance at the same time. This shows whether the step inputs are used, or correctly ignored. Random writes place the value in three regions: near zero, near the all-ones value, and anywhere. The first two regions separate clamping from wrapping, and an underflow from an overflow. Directed cases start above the ceiling and below the floor to confirm the unchanged-value rule. They also drive a write together with a request to confirm that the write wins. Concurrent up and down requests with unequal dynamic steps show whether the net difference or a single direction is applied.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } cnt_dir_e;
endpackage

// File: rtl/evt_cnt_step.sv
module evt_cnt_step #(
  parameter int unsigned W      = 32,
  parameter int unsigned STEP_W = 8,
  parameter bit          DYN    = 1'b0,
  parameter logic [W-1:0] UP_STEP = 2,
  parameter logic [W-1:0] DN_STEP = 2
) (
  input  logic [1:0]             en,
  input  logic [1:0][STEP_W-1:0] dyn_step,
  output logic [1:0][W-1:0]      amt
);
  localparam logic [1:0][W-1:0] FIXED = {DN_STEP, UP_STEP};

  // index 0 = up, index 1 = down
  for (genvar d = 0; d < 2; d++) begin : g_dir
    always_comb begin
      if (!en[d])   amt[d] = '0;
      else if (DYN) amt[d] = W'(dyn_step[d]);
      else          amt[d] = FIXED[d];
    end
  end
endmodule

// File: rtl/evt_cnt_next.sv
module evt_cnt_next
  import evt_cnt_pkg::*;
#(
  parameter int unsigned  W     = 32,
  parameter logic [W-1:0] CEIL  = 15,
  parameter logic [W-1:0] FLOOR = 5
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] up_amt,
  input  logic [W-1:0] dn_amt,
  input  logic         up_sat,
  input  logic         dn_sat,
  output logic [W-1:0] nxt,
  output logic         ovf,
  output logic         unf,
  output logic         clamp,
  output cnt_dir_e     dir
);
  localparam int unsigned XW = W + 2;

  function automatic logic signed [XW-1:0] widen(input logic [W-1:0] x);
    return $signed({2'b00, x});
  endfunction

  logic signed [XW-1:0] delta;
  logic signed [XW-1:0] sum;

  always_comb begin
    delta = widen(up_amt) - widen(dn_amt);
    sum   = widen(cur) + delta;
    if (delta[XW-1])  dir = DIR_DOWN;
    else if (|delta)  dir = DIR_UP;
    else              dir = DIR_HOLD;

    nxt   = cur;
    ovf   = 1'b0;
    unf   = 1'b0;
    clamp = 1'b0;
    unique case (dir)
      DIR_UP: begin
        if (up_sat && (sum > widen(CEIL))) begin
          clamp = 1'b1;
          nxt   = (cur > CEIL) ? cur : CEIL;
        end else begin
          nxt = sum[W-1:0];
          ovf = !up_sat && sum[W];
        end
      end
      DIR_DOWN: begin
        if (dn_sat && (sum < widen(FLOOR))) begin
          clamp = 1'b1;
          nxt   = (cur < FLOOR) ? cur : FLOOR;
        end else begin
          nxt = sum[W-1:0];
          unf = !dn_sat && sum[XW-1];
        end
      end
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/evt_cnt_flags.sv
module evt_cnt_flags #(
  parameter int unsigned  W      = 32,
  parameter logic [W-1:0] HI_THR = 10,
  parameter logic [W-1:0] LO_THR = 10
) (
  input  logic [W-1:0] val,
  output logic         hi_flag,
  output logic         lo_flag
);
  always_comb begin
    hi_flag = (val >= HI_THR);
    lo_flag = (val <= LO_THR);
  end
endmodule

// File: rtl/evt_counter.sv
module evt_counter
  import evt_cnt_pkg::*;
#(
  parameter int unsigned WIDTH     = 32,
  parameter int unsigned STEP_W    = 8,
  parameter bit          DYN_STEP  = 1'b0,
  parameter int unsigned INC_STEP  = 2,
  parameter int unsigned DEC_STEP  = 2,
  parameter int unsigned INC_CEIL  = 15,
  parameter int unsigned DEC_FLOOR = 5,
  parameter int unsigned INC_THR   = 10,
  parameter int unsigned DEC_THR   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_i,
  input  logic              dec_i,
  input  logic [STEP_W-1:0] inc_step_i,
  input  logic [STEP_W-1:0] dec_step_i,
  input  logic              inc_sat_i,
  input  logic              dec_sat_i,
  input  logic              sw_we_i,
  input  logic [WIDTH-1:0]  sw_wdata_i,
  output logic [WIDTH-1:0]  sw_rdata_o,
  output logic              inc_thr_o,
  output logic              dec_thr_o,
  output logic              ovf_o,
  output logic              unf_o
);
  localparam logic [WIDTH-1:0] UP_STEP_C = WIDTH'(INC_STEP);
  localparam logic [WIDTH-1:0] DN_STEP_C = WIDTH'(DEC_STEP);
  localparam logic [WIDTH-1:0] CEIL_C    = WIDTH'(INC_CEIL);
  localparam logic [WIDTH-1:0] FLOOR_C   = WIDTH'(DEC_FLOOR);
  localparam logic [WIDTH-1:0] HI_THR_C  = WIDTH'(INC_THR);
  localparam logic [WIDTH-1:0] LO_THR_C  = WIDTH'(DEC_THR);

  logic [WIDTH-1:0]      cnt_q;
  logic [1:0][WIDTH-1:0] step_amt;
  logic [WIDTH-1:0]      nxt_val;
  logic                  nxt_ovf;
  logic                  nxt_unf;
  logic                  clamp_hit;
  cnt_dir_e              cnt_dir;

  evt_cnt_step #(
    .W(WIDTH), .STEP_W(STEP_W), .DYN(DYN_STEP),
    .UP_STEP(UP_STEP_C), .DN_STEP(DN_STEP_C)
  ) u_step (
    .en      ({dec_i, inc_i}),
    .dyn_step({dec_step_i, inc_step_i}),
    .amt     (step_amt)
  );

  evt_cnt_next #(
    .W(WIDTH), .CEIL(CEIL_C), .FLOOR(FLOOR_C)
  ) u_next (
    .cur   (cnt_q),
    .up_amt(step_amt[0]),
    .dn_amt(step_amt[1]),
    .up_sat(inc_sat_i),
    .dn_sat(dec_sat_i),
    .nxt   (nxt_val),
    .ovf   (nxt_ovf),
    .unf   (nxt_unf),
    .clamp (clamp_hit),
    .dir   (cnt_dir)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else if (sw_we_i) begin
      cnt_q <= sw_wdata_i;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      cnt_q <= nxt_val;
      ovf_o <= nxt_ovf;
      unf_o <= nxt_unf;
    end
  end

  evt_cnt_flags #(
    .W(WIDTH), .HI_THR(HI_THR_C), .LO_THR(LO_THR_C)
  ) u_flags (
    .val    (cnt_q),
    .hi_flag(inc_thr_o),
    .lo_flag(dec_thr_o)
  );

  assign sw_rdata_o = cnt_q;
endmodule

// File: rtl/evt_counter_chk.sv
module evt_counter_chk #(
  parameter int unsigned WIDTH     = 32,
  parameter int unsigned INC_CEIL  = 15,
  parameter int unsigned DEC_FLOOR = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inc_i,
  input logic             dec_i,
  input logic             inc_sat_i,
  input logic             dec_sat_i,
  input logic             sw_we_i,
  input logic [WIDTH-1:0] sw_wdata_i,
  input logic [WIDTH-1:0] sw_rdata_o,
  input logic             ovf_o,
  input logic             unf_o
);
  localparam logic [WIDTH-1:0] CEIL_V  = WIDTH'(INC_CEIL);
  localparam logic [WIDTH-1:0] FLOOR_V = WIDTH'(DEC_FLOOR);

  // R2
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we_i |=> (sw_rdata_o == $past(sw_wdata_i)) && !ovf_o && !unf_o);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we_i && !inc_i && !dec_i) |=> $stable(sw_rdata_o) && !ovf_o && !unf_o);

  // R6
  ceil_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we_i && inc_sat_i && (dec_sat_i || !dec_i) && (sw_rdata_o <= CEIL_V))
      |=> (sw_rdata_o <= CEIL_V));

  // R7
  floor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we_i && dec_sat_i && (inc_sat_i || !inc_i) && (sw_rdata_o >= FLOOR_V))
      |=> (sw_rdata_o >= FLOOR_V));

  // R8
  ovf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> $past(inc_i) && !$past(inc_sat_i) && (sw_rdata_o < $past(sw_rdata_o)));

  // R9
  unf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o |-> $past(dec_i) && !$past(dec_sat_i) && (sw_rdata_o > $past(sw_rdata_o)));

  // R8
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_o && unf_o));
endmodule

bind evt_counter evt_counter_chk #(
  .WIDTH(WIDTH), .INC_CEIL(INC_CEIL), .DEC_FLOOR(DEC_FLOOR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .inc_i(inc_i), .dec_i(dec_i),
  .inc_sat_i(inc_sat_i), .dec_sat_i(dec_sat_i), .sw_we_i(sw_we_i),
  .sw_wdata_i(sw_wdata_i), .sw_rdata_o(sw_rdata_o),
  .ovf_o(ovf_o), .unf_o(unf_o)
);

// File: tb/evt_counter_bench.sv
module evt_counter_bench;
  localparam longint MODV  = 64'h1_0000_0000;
  localparam longint CEIL  = 15;
  localparam longint FLOOR = 5;
  localparam longint HI_T  = 10;
  localparam longint LO_T  = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inc_i = 1'b0, dec_i = 1'b0, inc_sat_i = 1'b0, dec_sat_i = 1'b0, sw_we_i = 1'b0;
  logic [7:0]  inc_step_i = '0, dec_step_i = '0;
  logic [31:0] sw_wdata_i = '0;
  logic [31:0] rd_f, rd_d;
  logic        ith_f, dth_f, ov_f, un_f, ith_d, dth_d, ov_d, un_d;

  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;
  longint exp_f = 0, exp_d = 0;
  bit  eov_f, eun_f, eov_d, eun_d;
  string tag_f, tag_d;

  always #4 clk = ~clk;

  evt_counter u_evt_counter (
    .clk(clk), .rst_n(rst_n), .inc_i(inc_i), .dec_i(dec_i),
    .inc_step_i(inc_step_i), .dec_step_i(dec_step_i),
    .inc_sat_i(inc_sat_i), .dec_sat_i(dec_sat_i),
    .sw_we_i(sw_we_i), .sw_wdata_i(sw_wdata_i), .sw_rdata_o(rd_f),
    .inc_thr_o(ith_f), .dec_thr_o(dth_f), .ovf_o(ov_f), .unf_o(un_f));

  evt_counter #(.DYN_STEP(1'b1)) u_evt_counter_dyn (
    .clk(clk), .rst_n(rst_n), .inc_i(inc_i), .dec_i(dec_i),
    .inc_step_i(inc_step_i), .dec_step_i(dec_step_i),
    .inc_sat_i(inc_sat_i), .dec_sat_i(dec_sat_i),
    .sw_we_i(sw_we_i), .sw_wdata_i(sw_wdata_i), .sw_rdata_o(rd_d),
    .inc_thr_o(ith_d), .dec_thr_o(dth_d), .ovf_o(ov_d), .unf_o(un_d));

  // reference: next value, pulses and the requirement the case exercises
  function automatic void model(input longint v, input bit dyn, output longint nv,
                                output bit ov, output bit un, output string tag);
    longint up, dn, d, s;
    up = !inc_i ? 0 : (dyn ? longint'(inc_step_i) : 2);
    dn = !dec_i ? 0 : (dyn ? longint'(dec_step_i) : 2);
    d  = up - dn;
    s  = v + d;
    ov = 1'b0; un = 1'b0; nv = v;
    tag = dyn ? "R4" : "R3";
    if (sw_we_i) begin
      nv = longint'(sw_wdata_i); tag = "R2";
    end else if (d > 0) begin
      if (inc_sat_i && s > CEIL) begin nv = (v > CEIL) ? v : CEIL; tag = "R6"; end
      else if (!inc_sat_i && s >= MODV) begin nv = s - MODV; ov = 1'b1; tag = "R8"; end
      else nv = s;
    end else if (d < 0) begin
      if (dec_sat_i && s < FLOOR) begin nv = (v < FLOOR) ? v : FLOOR; tag = "R7"; end
      else if (!dec_sat_i && s < 0) begin nv = s + MODV; un = 1'b1; tag = "R9"; end
      else nv = s;
    end else if (!inc_i && !dec_i) tag = "R11";
    if (!sw_we_i && inc_i && dec_i) tag = {tag, "/R5"};
  endfunction

  task automatic cmp(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    cmp({"u_evt_counter ", tag_f}, longint'(rd_f), exp_f);
    cmp({"u_evt_counter ovf ", tag_f}, longint'(ov_f), longint'(eov_f));
    cmp({"u_evt_counter unf ", tag_f}, longint'(un_f), longint'(eun_f));
    cmp("u_evt_counter R10 hi", longint'(ith_f), longint'(exp_f >= HI_T));
    cmp("u_evt_counter R10 lo", longint'(dth_f), longint'(exp_f <= LO_T));
    cmp({"dyn ", tag_d}, longint'(rd_d), exp_d);
    cmp({"dyn ovf ", tag_d}, longint'(ov_d), longint'(eov_d));
    cmp({"dyn unf ", tag_d}, longint'(un_d), longint'(eun_d));
    cmp("dyn R10 hi", longint'(ith_d), longint'(exp_d >= HI_T));
    cmp("dyn R10 lo", longint'(dth_d), longint'(exp_d <= LO_T));
  endtask

  // called at a falling edge: drive, predict, wait one cycle, compare
  task automatic apply(input bit i, input bit d, input logic [7:0] is, input logic [7:0] ds,
                       input bit isat, input bit dsat, input bit we, input logic [31:0] wd);
    longint nf, nd;
    inc_i = i; dec_i = d; inc_step_i = is; dec_step_i = ds;
    inc_sat_i = isat; dec_sat_i = dsat; sw_we_i = we; sw_wdata_i = wd;
    model(exp_f, 1'b0, nf, eov_f, eun_f, tag_f);
    model(exp_d, 1'b1, nd, eov_d, eun_d, tag_d);
    exp_f = nf; exp_d = nd;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    eov_f = 0; eun_f = 0; eov_d = 0; eun_d = 0; tag_f = "R1"; tag_d = "R1";
    check_all();

    // directed corners
    apply(1, 0, 8'd0, 8'd0, 1, 1, 1, 32'd13);          // R2 load
    apply(1, 0, 8'd7, 8'd0, 1, 1, 0, 0);               // R6 clamp to 15
    apply(1, 0, 8'd1, 8'd0, 1, 1, 0, 0);               // R6 stay at ceiling
    apply(1, 1, 8'd9, 8'd9, 1, 1, 1, 32'd20);          // R2 write wins over requests
    apply(1, 0, 8'd3, 8'd0, 1, 1, 0, 0);               // R6 above ceiling unchanged
    apply(0, 0, 8'd0, 8'd0, 0, 0, 1, 32'd6);
    apply(0, 1, 8'd0, 8'd4, 1, 1, 0, 0);               // R7 clamp to floor
    apply(0, 0, 8'd0, 8'd0, 0, 0, 1, 32'd3);
    apply(0, 1, 8'd0, 8'd1, 1, 1, 0, 0);               // R7 below floor unchanged
    apply(0, 0, 8'd0, 8'd0, 0, 0, 0, 0);               // R11 hold
    apply(0, 0, 8'd0, 8'd0, 0, 0, 1, 32'hFFFF_FFFF);
    apply(1, 0, 8'd5, 8'd0, 0, 0, 0, 0);               // R8 wrap up
    apply(0, 0, 8'd0, 8'd0, 0, 0, 1, 32'd1);
    apply(0, 1, 8'd0, 8'd6, 0, 0, 0, 0);               // R9 wrap down
    apply(0, 0, 8'd0, 8'd0, 0, 0, 1, 32'd100);
    apply(1, 1, 8'd9, 8'd3, 0, 0, 0, 0);               // R5 net up (dyn +6, fixed 0)
    apply(1, 1, 8'd2, 8'd7, 0, 0, 0, 0);               // R5 net down

    // constrained random
    for (int k = 0; k < 4000; k++) begin
      int sel;
      logic [31:0] wd;
      sel = $urandom_range(0, 2);
      if (sel == 0)      wd = $urandom_range(0, 24);
      else if (sel == 1) wd = 32'hFFFF_FFFF - $urandom_range(0, 20);
      else               wd = $urandom;
      apply($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
            8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)),
            $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
            $urandom_range(0, 9) == 0, wd);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule